// File: doc/BRIEF.md
# Power-Up Register Initialization Sequencer

This block brings a timing-generator device out of power-up by issuing a fixed, order-critical list of register writes on a simple address/data write port. A serial shifter outside the block picks up each write and sends it to the device. After reset the sequencer does nothing until the master clock input is reported stable. It then pulses a soft reset, loads the two initialization constants, selects master timing, releases the timing core and arms the synchronization controls. Writes are held on the port until they are accepted.

After the arming writes the sequencer stops. It raises a flag that hands the port to the user's own timing configuration and waits for a one-cycle done pulse. It then writes the output-enable register and clears the update lock, and raises a sticky done flag. Only a reset can start a new sequence.

Top module: `pwrup_init_seq`

## Requirements
- R1: While reset is asserted, and at release, `wr_valid`, `user_phase` and `seq_done` are low.
- R2: No write is offered until `clk_stable` has been sampled high on STABLE_CYCLES consecutive rising edges. A low sample restarts the count.
- R3: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged on the next cycle. A write counts as accepted on an edge where both are high.
- R4: The writes before the user phase are offered in this order, as (address, data): (0x017,1), (0x017,0), (0x02B,53), (0x010,4), (0x0EB,1), (0x029,1), (0x01B,1), (0x024,1), (0x026,1).
- R5: One cycle after the ninth write is accepted, `user_phase` is high and `wr_valid` is low. Both stay that way until `user_done` is sampled high.
- R6: On the cycle after `user_done` is sampled during the user phase, the write (0x018,1) is offered. After it is accepted, the write (0x01B,0) follows.
- R7: One cycle after the eleventh write is accepted, `seq_done` goes high and stays high until reset. From then on `wr_valid` and `user_phase` stay low.
- R8: Once the first write has been offered, `clk_stable` has no effect on the sequence.
- R9: The first write appears one cycle after the edge that completes the stable count. While `wr_ready` is held high, one write is accepted on every cycle.
- R10: `user_done` has no effect outside the user phase: it neither skips writes nor causes writes after `seq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_stable | input | 1 | High while the master clock input is applied and stable |
| wr_valid | output | 1 | A register write is offered |
| wr_addr | output | ADDR_W | Register address of the offered write |
| wr_data | output | DATA_W | Data of the offered write |
| wr_ready | input | 1 | The serial shifter accepts the offered write |
| user_phase | output | 1 | The user configuration window is open |
| user_done | input | 1 | One-cycle pulse that closes the user window |
| seq_done | output | 1 | The whole sequence has completed |

## Verification
The bench builds the block with STABLE_CYCLES set to 3 and the default 12-bit address and 6-bit data. This keeps the stable-clock qualification short enough to interrupt with a glitch and still observe the count restarting. The bench runs two full sequences. One uses `wr_ready` held high, to show the one-write-per-cycle rate. The other uses a ready pattern that stalls one cycle in three, combined with a `clk_stable` drop in the middle of the sequence and a stray `user_done` pulse while writes are still in progress.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_CLK,
        ST_WRITE,
        ST_USER,
        ST_DONE
    } seq_state_e;

    localparam int NUM_STEPS  = 11;
    localparam int LAST_PRE   = 8;   // last write before the user window
    localparam int FIRST_POST = 9;   // first write after the user window
    localparam int LAST_STEP  = NUM_STEPS - 1;
    localparam int STEP_IDX_W = $clog2(NUM_STEPS + 1);

    localparam int TBL_ADDR_W = 12;
    localparam int TBL_DATA_W = 6;

    // {address, data} of each step; order is the behaviour
    function automatic logic [TBL_ADDR_W+TBL_DATA_W-1:0] step_word(input logic [STEP_IDX_W-1:0] idx);
        logic [TBL_ADDR_W-1:0] a;
        logic [TBL_DATA_W-1:0] d;
        case (idx)
            4'd0:    begin a = 12'h017; d = 6'd1;  end
            4'd1:    begin a = 12'h017; d = 6'd0;  end
            4'd2:    begin a = 12'h02B; d = 6'd53; end
            4'd3:    begin a = 12'h010; d = 6'd4;  end
            4'd4:    begin a = 12'h0EB; d = 6'd1;  end
            4'd5:    begin a = 12'h029; d = 6'd1;  end
            4'd6:    begin a = 12'h01B; d = 6'd1;  end
            4'd7:    begin a = 12'h024; d = 6'd1;  end
            4'd8:    begin a = 12'h026; d = 6'd1;  end
            4'd9:    begin a = 12'h018; d = 6'd1;  end
            4'd10:   begin a = 12'h01B; d = 6'd0;  end
            default: begin a = '0;      d = '0;    end
        endcase
        return {a, d};
    endfunction

endpackage

// File: rtl/pwrup_step_rom.sv
module pwrup_step_rom
    import pwrup_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 6
) (
    input  logic [STEP_IDX_W-1:0] idx,
    output logic [ADDR_W-1:0]     addr,
    output logic [DATA_W-1:0]     data
);
    localparam int WORD_W = TBL_ADDR_W + TBL_DATA_W;

    logic [WORD_W-1:0] word;

    always_comb begin
        word = step_word(idx);
        addr = ADDR_W'(word[WORD_W-1:TBL_DATA_W]);
        data = DATA_W'(word[TBL_DATA_W-1:0]);
    end
endmodule

// File: rtl/pwrup_stable_qual.sv
module pwrup_stable_qual #(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_stable,
    output logic stable_ok
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!clk_stable) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_MAX) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
        stable_ok = (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pwrup_wr_hold.sv
module pwrup_wr_hold #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              accepted
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d      = h_q;
        accepted = h_q.valid && wr_ready;
        if (load) begin
            h_d.valid = 1'b1;
            h_d.addr  = load_addr;
            h_d.data  = load_data;
        end else if (accepted) begin
            h_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign wr_valid = h_q.valid;
    assign wr_addr  = h_q.addr;
    assign wr_data  = h_q.data;
endmodule

// File: rtl/pwrup_init_seq.sv
module pwrup_init_seq
    import pwrup_seq_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int DATA_W        = 6,
    parameter int STABLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_stable,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              user_phase,
    input  logic              user_done,
    output logic              seq_done
);
    localparam logic [STEP_IDX_W-1:0] IDX_LAST_PRE   = STEP_IDX_W'(LAST_PRE);
    localparam logic [STEP_IDX_W-1:0] IDX_FIRST_POST = STEP_IDX_W'(FIRST_POST);
    localparam logic [STEP_IDX_W-1:0] IDX_LAST       = STEP_IDX_W'(LAST_STEP);

    typedef struct packed {
        seq_state_e             state;
        logic [STEP_IDX_W-1:0]  idx;
    } seq_t;

    seq_t s_d, s_q;

    logic                  stable_ok;
    logic                  accepted;
    logic                  load;
    logic [STEP_IDX_W-1:0] rom_idx;
    logic [ADDR_W-1:0]     rom_addr;
    logic [DATA_W-1:0]     rom_data;

    pwrup_stable_qual #(
        .STABLE_CYCLES(STABLE_CYCLES)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_stable (clk_stable),
        .stable_ok  (stable_ok)
    );

    pwrup_step_rom #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_rom (
        .idx  (rom_idx),
        .addr (rom_addr),
        .data (rom_data)
    );

    pwrup_wr_hold #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (rom_addr),
        .load_data (rom_data),
        .wr_ready  (wr_ready),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .accepted  (accepted)
    );

    always_comb begin
        s_d     = s_q;
        load    = 1'b0;
        rom_idx = s_q.idx + 1'b1;
        unique case (s_q.state)
            ST_WAIT_CLK: begin
                rom_idx = '0;
                if (stable_ok) begin
                    load      = 1'b1;
                    s_d.idx   = '0;
                    s_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (accepted) begin
                    if (s_q.idx == IDX_LAST_PRE) begin
                        s_d.state = ST_USER;
                    end else if (s_q.idx == IDX_LAST) begin
                        s_d.state = ST_DONE;
                    end else begin
                        load    = 1'b1;
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            ST_USER: begin
                rom_idx = IDX_FIRST_POST;
                if (user_done) begin
                    load      = 1'b1;
                    s_d.idx   = IDX_FIRST_POST;
                    s_d.state = ST_WRITE;
                end
            end
            ST_DONE: begin
                s_d = s_q;
            end
            default: begin
                s_d = s_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= ST_WAIT_CLK;
            s_q.idx   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign user_phase = (s_q.state == ST_USER);
    assign seq_done   = (s_q.state == ST_DONE);
endmodule

// File: rtl/pwrup_init_seq_chk.sv
module pwrup_init_seq_chk #(
    parameter int ADDR_W        = 12,
    parameter int DATA_W        = 6,
    parameter int STABLE_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_stable,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_ready,
    input logic              user_phase,
    input logic              seq_done
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

    logic [CNT_W-1:0] run_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (!clk_stable) begin
                run_q <= '0;
            end else if (run_q != CNT_W'(STABLE_CYCLES)) begin
                run_q <= run_q + 1'b1;
            end
            if (run_q == CNT_W'(STABLE_CYCLES)) begin
                seen_q <= 1'b1;
            end
        end
    end

    // R2
    p_wait_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> seen_q);

    // R3
    p_hold_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R5
    p_user_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        user_phase |-> !wr_valid);

    // R7
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> seq_done);

    // R7
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!wr_valid && !user_phase));

    // R1
    p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, user_phase, seq_done}));
endmodule

bind pwrup_init_seq pwrup_init_seq_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .STABLE_CYCLES(STABLE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_stable (clk_stable),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .user_phase (user_phase),
    .seq_done   (seq_done)
);

// File: tb/tb_pwrup_init_seq.sv
module tb_pwrup_init_seq;
    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clk_stable;
    logic        wr_valid;
    logic [11:0] wr_addr;
    logic [5:0]  wr_data;
    logic        wr_ready;
    logic        user_phase;
    logic        user_done;
    logic        seq_done;

    always #5 clk = ~clk;

    pwrup_init_seq #(.ADDR_W(12), .DATA_W(6), .STABLE_CYCLES(N)) dut (
        .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .user_phase(user_phase),
        .user_done(user_done), .seq_done(seq_done)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    int exp_addr[11] = '{'h017, 'h017, 'h02B, 'h010, 'h0EB, 'h029, 'h01B, 'h024, 'h026, 'h018, 'h01B};
    int exp_data[11] = '{1, 0, 53, 4, 1, 1, 1, 1, 1, 1, 0};

    // behavioural reference: 0 wait, 1 writing, 2 user window, 3 finished
    int m_state, m_idx, m_cnt, acc_count;
    bit m_valid;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_idx = 0; m_cnt = 0; m_valid = 0; acc_count = 0;
        end else begin
            if (m_valid && wr_ready) acc_count++;
            case (m_state)
                0: if (m_cnt == N) begin m_state = 1; m_idx = 0; m_valid = 1; end
                1: if (wr_ready) begin
                       if (m_idx == 8) begin m_state = 2; m_valid = 0; end
                       else if (m_idx == 10) begin m_state = 3; m_valid = 0; end
                       else m_idx++;
                   end
                2: if (user_done) begin m_state = 1; m_idx = 9; m_valid = 1; end
                default: ;
            endcase
            if (!clk_stable) m_cnt = 0;
            else if (m_cnt < N) m_cnt++;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(wr_valid === m_valid, "R9", wr_valid, m_valid);
            if (m_valid) begin
                chk(wr_addr == exp_addr[m_idx[3:0]], (m_idx < 9) ? "R4" : "R6", wr_addr, exp_addr[m_idx[3:0]]);
                chk(wr_data == exp_data[m_idx[3:0]], (m_idx < 9) ? "R4" : "R6", wr_data, exp_data[m_idx[3:0]]);
            end
            chk(user_phase === (m_state == 2), "R5", user_phase, m_state == 2);
            chk(seq_done === (m_state == 3), "R7", seq_done, m_state == 3);
        end
    end

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        wait (cyc >= 20000);
        failures++;
        $display("FAIL watchdog R7 actual=timeout expected=seq_done");
        summary();
        $finish;
    end

    initial begin
        logic        pv, pr;
        logic [11:0] pa;
        logic [5:0]  pd;
        int          uwait;
        bit          seen_user;
        rst_n = 0; clk_stable = 0; wr_ready = 0; user_done = 0;
        repeat (3) @(negedge clk);
        chk(wr_valid == 0, "R1", wr_valid, 0);
        chk(user_phase == 0, "R1", user_phase, 0);
        chk(seq_done == 0, "R1", seq_done, 0);

        // run 1: glitch on clk_stable, ready always high
        rst_n = 1; wr_ready = 1;
        chk(wr_valid == 0, "R1", wr_valid, 0);
        clk_stable = 1;
        @(negedge clk); @(negedge clk);
        clk_stable = 0;
        @(negedge clk);
        clk_stable = 1;
        repeat (N) begin
            @(negedge clk);
            chk(wr_valid == 0, "R2", wr_valid, 0);
        end
        @(negedge clk);
        chk(wr_valid == 1, "R9", wr_valid, 1);
        while (!user_phase) @(negedge clk);
        chk(acc_count == 9, "R5", acc_count, 9);
        repeat (2) @(negedge clk);
        chk(user_phase && !wr_valid, "R5", {user_phase, wr_valid}, 2);
        user_done = 1;
        @(negedge clk);
        user_done = 0;
        chk(wr_valid && wr_addr == 12'h018, "R6", wr_addr, 12'h018);
        while (!seq_done) @(negedge clk);
        chk(acc_count == 11, "R7", acc_count, 11);
        user_done = 1;
        @(negedge clk);
        user_done = 0;
        repeat (4) begin
            @(negedge clk);
            chk(!wr_valid && seq_done && !user_phase, "R10", {wr_valid, seq_done, user_phase}, 2);
        end

        // run 2: stalls, stray user_done, clk_stable drop mid-sequence
        rst_n = 0;
        @(negedge clk);
        rst_n = 1; clk_stable = 1; user_done = 0;
        pv = 0; pr = 0; pa = '0; pd = '0; uwait = 0; seen_user = 0;
        for (int k = 0; k < 400 && !seq_done; k++) begin
            if (pv && !pr)
                chk(wr_valid && wr_addr == pa && wr_data == pd, "R3", {wr_valid, wr_addr, wr_data}, {1'b1, pa, pd});
            if (user_phase && !seen_user) begin
                seen_user = 1;
                chk(acc_count == 9, "R10", acc_count, 9);
            end
            if (k == 12)
                chk(wr_valid == 1, "R8", wr_valid, 1);
            if (user_phase) uwait++;
            wr_ready   = (k % 3) != 1;
            clk_stable = !(k >= 9 && k < 13);
            user_done  = (k == 8) || (user_phase && uwait == 3);
            pv = wr_valid; pr = wr_ready; pa = wr_addr; pd = wr_data;
            @(negedge clk);
        end
        user_done = 0;
        chk(seq_done == 1, "R8", seq_done, 1);
        chk(acc_count == 11, "R10", acc_count, 11);

        summary();
        $finish;
    end
endmodule